// File: doc/BRIEF.md
# Indirect Interrupt Register Access Router

This block sits between a hart's indirect register access port and an interrupt file that holds the per-page interrupt state. Each request carries a privilege level, a virtualization flag, a guest-select index, a flag for 64-bit register width and an 8-bit register select. The router works out which page of the interrupt file the access targets. It then resolves the select into a register kind and a word index, and passes the write data, the write mask and the read data through. When the access cannot be routed, nothing reaches the file.

The router is built in one of two forms. The machine-level form has a single page and accepts only machine-privilege, non-virtualized accesses. The supervisor-level form has several pages: page 0 serves the host supervisor, and pages 1 and up serve virtualized guests. Decoding is combinational, so a request is routed in the same cycle it is presented. A rejected request produces a one-cycle error flag on the following clock edge.

Top module: `irq_route_top`

## Requirements
- R1: With MACHINE_MODE=1, a request is accepted only when the privilege is 2'b11 and the virtualization flag is 0, and it maps to page 0. Every other privilege or flag combination is rejected.
- R2: With MACHINE_MODE=0, only privilege 2'b01 is accepted. A non-virtualized supervisor request maps to page 0.
- R3: With MACHINE_MODE=0, a virtualized supervisor request maps to the page equal to the guest-select index. It is accepted only when that index is nonzero and below NUM_PAGES. In machine mode the page count is 1, whatever NUM_PAGES is.
- R4: The select decodes as follows, with kind codes in brackets: 8'h70 delivery [0], 8'h72 threshold [1], 8'h7F top-identity [2], 8'h80 to 8'hBF pending word [3], 8'hC0 to 8'hFF enable word [4]. Any other select is rejected.
- R5: With 32-bit width, a pending or enable select gives word index = select bits [5:0].
- R6: With 64-bit width, a pending or enable select is rejected when select bit 0 is 1. An even select gives word index = select bits [5:1].
- R7: A pending or enable access is rejected when its word index is at or above NUM_IDS/32 (32-bit width) or NUM_IDS/64 (64-bit width).
- R8: A rejected request holds fileValid at 0, drives fileWrData and fileWrMask to zero, and returns zero on reqRdData.
- R9: errFlag rises on the clock edge after a cycle that holds a rejected request, and stays high for that one cycle only. It is low after reset and after accepted or idle cycles.
- R10: An accepted request raises fileValid in the same cycle. It forwards reqWrData and reqWrMask unchanged, and returns fileRdData unchanged on reqRdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqPriv | input | 2 | Privilege of the requester (2'b11 machine, 2'b01 supervisor) |
| reqVirt | input | 1 | Request comes from a virtualized context |
| reqGuest | input | GW | Guest-select index |
| reqXlen64 | input | 1 | 1 = 64-bit register width, 0 = 32-bit |
| reqSel | input | 8 | Register select number |
| reqWrData | input | DW | Write data |
| reqWrMask | input | DW | Write bit mask |
| reqRdData | output | DW | Read data returned to the requester |
| fileValid | output | 1 | Routed access to the interrupt file |
| filePage | output | PW | Target page |
| fileKind | output | 3 | Register kind code |
| fileWord | output | 6 | Word index for pending or enable arrays |
| fileWrData | output | DW | Forwarded write data |
| fileWrMask | output | DW | Forwarded write mask |
| fileRdData | input | DW | Read data from the interrupt file |
| errFlag | output | 1 | One-cycle flag for a rejected request |

## Verification
The assertions assume that request inputs change only between rising edges and are stable at each edge, since they sample combinational outputs there. They also assume that the guest index is at least as wide as the page index. The bench drives every request at the falling edge and holds it for a full cycle. It keeps GW wider than the page field, and it returns to an idle cycle before each error-flag check that depends on a clean previous cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [2:0] {
    KIND_DELIV  = 3'd0,
    KIND_THRESH = 3'd1,
    KIND_TOPID  = 3'd2,
    KIND_PEND   = 3'd3,
    KIND_ENAB   = 3'd4,
    KIND_NONE   = 3'd7
  } regKind_e;

  localparam logic [7:0] SEL_DELIV  = 8'h70;
  localparam logic [7:0] SEL_THRESH = 8'h72;
  localparam logic [7:0] SEL_TOPID  = 8'h7F;

  localparam logic [1:0] PRIV_MACH = 2'b11;
  localparam logic [1:0] PRIV_SUP  = 2'b01;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic fwd;   // pass data through to the file
    logic drop;  // request rejected, force kind to none
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter bit MACHINE_MODE = 1'b0,
  parameter int NUM_PAGES    = 5,
  parameter int GW           = 6,
  parameter int PW           = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [1:0]    reqPriv,
  input  logic          reqVirt,
  input  logic [GW-1:0] reqGuest,
  input  logic          selOk,
  output logic          fileValid,
  output logic [PW-1:0] filePage,
  output ctrlStrobe_t   strobes,
  output logic          errFlag
);

  localparam int EFF_PAGES = MACHINE_MODE ? 1 : NUM_PAGES;

  logic privOk;
  logic accept;

  always_comb begin
    privOk   = 1'b0;
    filePage = '0;
    if (MACHINE_MODE) begin
      privOk = (reqPriv == PRIV_MACH) && !reqVirt;
    end else if (reqPriv == PRIV_SUP) begin
      if (reqVirt) begin
        privOk   = (reqGuest != '0) && (int'(reqGuest) < EFF_PAGES);
        filePage = PW'(reqGuest);
      end else begin
        privOk = 1'b1;
      end
    end
  end

  assign accept       = reqValid && privOk && selOk;
  assign fileValid    = accept;
  assign strobes.fwd  = accept;
  assign strobes.drop = !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errFlag <= 1'b0;
    else        errFlag <= reqValid && !accept;
  end

  // R9: flag only follows a cycle with a rejected request
  assert_err_follows_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> $past(reqValid && !fileValid));

  // R3: guest pages are never zero and stay inside the page count
  assert_guest_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fileValid && reqVirt) |-> (filePage != '0 && int'(filePage) < EFF_PAGES));

  generate
    if (MACHINE_MODE) begin : g_mach
      // R1: machine form routes only to page 0 from machine privilege
      assert_machine_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fileValid |-> (filePage == '0 && reqPriv == PRIV_MACH && !reqVirt));
    end else begin : g_sup
      // R2: supervisor form never routes other privileges
      assert_sup_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fileValid |-> (reqPriv == PRIV_SUP));
    end
  endgenerate

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_IDS = 256,
  parameter int DW      = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reqSel,
  input  logic          reqXlen64,
  input  logic [DW-1:0] reqWrData,
  input  logic [DW-1:0] reqWrMask,
  input  logic [DW-1:0] fileRdData,
  input  ctrlStrobe_t   strobes,
  output logic          selOk,
  output logic [2:0]    fileKind,
  output logic [5:0]    fileWord,
  output logic [DW-1:0] fileWrData,
  output logic [DW-1:0] fileWrMask,
  output logic [DW-1:0] reqRdData
);

  localparam int         LIM32  = NUM_IDS / 32;
  localparam int         LIM64  = NUM_IDS / 64;
  localparam logic [6:0] LIM32W = 7'(LIM32);
  localparam logic [6:0] LIM64W = 7'(LIM64);

  regKind_e   kind;
  logic [5:0] rawNum;
  logic       arrayHit;
  logic       arrayOk;

  assign rawNum   = reqSel[5:0];
  assign arrayHit = reqSel[7];

  always_comb begin
    kind  = KIND_NONE;
    selOk = 1'b0;
    if (arrayHit) begin
      kind  = reqSel[6] ? KIND_ENAB : KIND_PEND;
      selOk = arrayOk;
    end else begin
      case (reqSel)
        SEL_DELIV:  begin kind = KIND_DELIV;  selOk = 1'b1; end
        SEL_THRESH: begin kind = KIND_THRESH; selOk = 1'b1; end
        SEL_TOPID:  begin kind = KIND_TOPID;  selOk = 1'b1; end
        default:    begin kind = KIND_NONE;   selOk = 1'b0; end
      endcase
    end
  end

  always_comb begin
    if (reqXlen64) begin
      fileWord = {1'b0, rawNum[5:1]};
      arrayOk  = !rawNum[0] && ({1'b0, fileWord} < LIM64W);
    end else begin
      fileWord = rawNum;
      arrayOk  = {1'b0, fileWord} < LIM32W;
    end
  end

  assign fileKind   = strobes.drop ? KIND_NONE : kind;
  assign fileWrData = strobes.fwd ? reqWrData  : '0;
  assign fileWrMask = strobes.fwd ? reqWrMask  : '0;
  assign reqRdData  = strobes.fwd ? fileRdData : '0;

  // R6: accepted 64-bit array selects are even and halved
  assert_even_halved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.fwd && arrayHit && reqXlen64) |-> (!reqSel[0] && fileWord == {1'b0, reqSel[5:1]}));

  // R7: accepted array words stay below the identity bound
  assert_word_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.fwd && arrayHit) |->
      ({1'b0, fileWord} < (reqXlen64 ? LIM64W : LIM32W)));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter bit MACHINE_MODE = 1'b0,
  parameter int NUM_PAGES    = 5,
  parameter int NUM_IDS      = 256,
  parameter int GW           = 6,
  parameter int DW           = 64,
  parameter int PW           = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic [1:0]    reqPriv,
  input  logic          reqVirt,
  input  logic [GW-1:0] reqGuest,
  input  logic          reqXlen64,
  input  logic [7:0]    reqSel,
  input  logic [DW-1:0] reqWrData,
  input  logic [DW-1:0] reqWrMask,
  output logic [DW-1:0] reqRdData,
  output logic          fileValid,
  output logic [PW-1:0] filePage,
  output logic [2:0]    fileKind,
  output logic [5:0]    fileWord,
  output logic [DW-1:0] fileWrData,
  output logic [DW-1:0] fileWrMask,
  input  logic [DW-1:0] fileRdData,
  output logic          errFlag
);

  ctrlStrobe_t strobes;
  logic        selOk;

  irq_route_ctrl #(
    .MACHINE_MODE(MACHINE_MODE), .NUM_PAGES(NUM_PAGES), .GW(GW), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .reqGuest(reqGuest), .selOk(selOk),
    .fileValid(fileValid), .filePage(filePage), .strobes(strobes),
    .errFlag(errFlag)
  );

  irq_route_dp #(.NUM_IDS(NUM_IDS), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqSel(reqSel), .reqXlen64(reqXlen64),
    .reqWrData(reqWrData), .reqWrMask(reqWrMask), .fileRdData(fileRdData),
    .strobes(strobes), .selOk(selOk), .fileKind(fileKind),
    .fileWord(fileWord), .fileWrData(fileWrData), .fileWrMask(fileWrMask),
    .reqRdData(reqRdData)
  );

  // R8: nothing leaks to either side when the request is not routed
  assert_quiet_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fileValid |-> (fileWrMask == '0 && fileWrData == '0 && reqRdData == '0));

endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqPriv = 2'b01;
  logic        reqVirt = 1'b0;
  logic [5:0]  reqGuest = '0;
  logic        reqXlen64 = 1'b0;
  logic [7:0]  reqSel = '0;
  logic [63:0] reqWrData = '0;
  logic [63:0] reqWrMask = '0;
  logic [63:0] fileRdData = '0;

  logic [63:0] rd0, wd0, wm0, rd1, wd1, wm1;
  logic        fv0, fv1, err0, err1;
  logic [2:0]  pg0;
  logic        pg1;
  logic [2:0]  kd0, kd1;
  logic [5:0]  wo0, wo1;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_route_top #(.MACHINE_MODE(1'b0), .NUM_PAGES(5), .NUM_IDS(256)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .reqGuest(reqGuest), .reqXlen64(reqXlen64),
    .reqSel(reqSel), .reqWrData(reqWrData), .reqWrMask(reqWrMask),
    .reqRdData(rd0), .fileValid(fv0), .filePage(pg0), .fileKind(kd0),
    .fileWord(wo0), .fileWrData(wd0), .fileWrMask(wm0),
    .fileRdData(fileRdData), .errFlag(err0)
  );

  irq_route_top #(.MACHINE_MODE(1'b1), .NUM_PAGES(1), .NUM_IDS(256)) u1 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .reqGuest(reqGuest), .reqXlen64(reqXlen64),
    .reqSel(reqSel), .reqWrData(reqWrData), .reqWrMask(reqWrMask),
    .reqRdData(rd1), .fileValid(fv1), .filePage(pg1), .fileKind(kd1),
    .fileWord(wo1), .fileWrData(wd1), .fileWrMask(wm1),
    .fileRdData(fileRdData), .errFlag(err1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic v, input logic [5:0] g,
                       input logic x64, input logic [7:0] s);
    @(negedge clk);
    reqValid = 1'b1; reqPriv = p; reqVirt = v; reqGuest = g;
    reqXlen64 = x64; reqSel = s;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    #1;
  endtask

  // u0 outcome checks
  task automatic expectOk(input string req, input logic [2:0] pg,
                          input logic [2:0] kd, input logic [5:0] wo, input bit chkWord);
    check(fv0 == 1'b1, req, "valid", fv0, 1);
    check(pg0 == pg, req, "page", pg0, pg);
    check(kd0 == kd, req, "kind", kd0, kd);
    if (chkWord) check(wo0 == wo, req, "word", wo0, wo);
  endtask

  task automatic expectRej(input string req);
    check(fv0 == 1'b0, req, "valid", fv0, 0);
    check(wm0 == 64'd0 && wd0 == 64'd0, req, "wrmask/data zero", wm0 | wd0, 0);
    check(rd0 == 64'd0, req, "rddata zero", rd0, 0);
    @(negedge clk); #1;
    check(err0 == 1'b1, "R9", "err after reject", err0, 1);
  endtask

  task automatic testReset();
    check(err0 == 1'b0 && err1 == 1'b0, "R9", "err at reset", err0, 0);
  endtask

  task automatic testSupPages();
    drive(2'b01, 1'b0, 6'd3, 1'b0, 8'h70); expectOk("R2", 3'd0, 3'd0, 6'd0, 0);
    drive(2'b01, 1'b1, 6'd3, 1'b0, 8'h70); expectOk("R3", 3'd3, 3'd0, 6'd0, 0);
    drive(2'b01, 1'b1, 6'd4, 1'b0, 8'h72); expectOk("R3", 3'd4, 3'd1, 6'd0, 0);
    drive(2'b01, 1'b1, 6'd0, 1'b0, 8'h70); expectRej("R3");
    drive(2'b01, 1'b1, 6'd5, 1'b0, 8'h70); expectRej("R3");
    drive(2'b11, 1'b0, 6'd0, 1'b0, 8'h70); expectRej("R2");
    idle();
  endtask

  task automatic testSelects();
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h7F); expectOk("R4", 3'd0, 3'd2, 6'd0, 0);
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'hC2); expectOk("R4", 3'd0, 3'd4, 6'd2, 1);
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h71); expectRej("R4");
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h87); expectOk("R5", 3'd0, 3'd3, 6'd7, 1);
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h88); expectRej("R7");
    drive(2'b01, 1'b0, 6'd0, 1'b1, 8'h86); expectOk("R6", 3'd0, 3'd3, 6'd3, 1);
    drive(2'b01, 1'b0, 6'd0, 1'b1, 8'hC5); expectRej("R6");
    drive(2'b01, 1'b0, 6'd0, 1'b1, 8'h88); expectRej("R7");
    idle();
  endtask

  task automatic testForward();
    reqWrData = 64'hDEAD_BEEF_0123_4567;
    reqWrMask = 64'h0000_FFFF_0000_00F0;
    fileRdData = 64'h1357_9BDF_2468_ACE0;
    drive(2'b01, 1'b1, 6'd2, 1'b0, 8'h81);
    check(wd0 == reqWrData, "R10", "wrdata", wd0, reqWrData);
    check(wm0 == reqWrMask, "R10", "wrmask", wm0, reqWrMask);
    check(rd0 == fileRdData, "R10", "rddata", rd0, fileRdData);
    @(negedge clk); #1;
    check(err0 == 1'b0, "R9", "no err after accept", err0, 0);
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h00); expectRej("R8");
    idle();
    @(negedge clk); #1;
    check(err0 == 1'b0, "R9", "err one cycle only", err0, 0);
  endtask

  task automatic testMachine();
    drive(2'b11, 1'b0, 6'd3, 1'b0, 8'h72);
    check(fv1 == 1'b1 && pg1 == 1'b0, "R1", "machine accepted page0", {fv1, pg1}, 2'b10);
    drive(2'b11, 1'b1, 6'd1, 1'b0, 8'h72);
    check(fv1 == 1'b0, "R1", "machine virt rejected", fv1, 0);
    @(negedge clk); #1;
    check(err1 == 1'b1, "R1", "machine err", err1, 1);
    drive(2'b01, 1'b0, 6'd0, 1'b0, 8'h72);
    check(fv1 == 1'b0, "R1", "machine sup rejected", fv1, 0);
    idle();
  endtask

  initial begin
    #1;
    testReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    testReset();
    testSupPages();
    testSelects();
    testForward();
    testMachine();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule